// File: doc/BRIEF.md
# Sync Stability Panel Guard

This block decides whether the display timing that feeds a flat panel is trustworthy enough to power the panel, and it demands an orderly power-down when that trust is lost. It watches the horizontal and vertical sync strobes, a "input clock present" level and a PLL lock level, all sampled on a free-running reference clock. The horizontal strobes are counted between vertical strobes. The timing is called stable only after three complete frames in a row produce the same line count. Two watchdogs run alongside the count. One covers a missing horizontal strobe, over a fixed number of reference cycles. The other covers a missing vertical strobe, over twice the most recently measured frame length.

Each of the three checks (PLL lock, sync, clock present) has its own bypass input. The panel power sequencer reads `timing_ok` to start power-up. It drives `panel_on` while the panel is powered. If any check that is not bypassed fails while `panel_on` is high, the guard raises `fault_req` and holds it until the sequencer drops `panel_on`. A controller with three states handles this:
- MON_WAIT: not yet good. It goes to MON_GOOD when all checks pass, and to MON_TRIP when a check fails while the panel is on.
- MON_GOOD: `timing_ok` is high. When a check fails it goes to MON_TRIP if the panel is on, otherwise back to MON_WAIT.
- MON_TRIP: `fault_req` is high. It returns to MON_WAIT once `panel_on` is low.

The line-count history has two states:
- HIST_EMPTY: no vertical strobe seen since reset or since the last sync loss.
- HIST_TRACK: counting, with a run length of matching frames.

Top module: `panel_sync_guard`

## Requirements
- R1: After reset, `timing_ok` and `fault_req` are both 0.
- R2: A frame is the interval between two rising edges of `vsync`. Its line count is the number of `hsync` rising edges in that interval. With the other checks passing, `timing_ok` rises only once three consecutive complete frames have equal line counts. With fewer than three matching frames, `timing_ok` stays 0.
- R3: A frame whose line count differs from the previous frame's count restarts the run at one. `timing_ok` returns only after three further equal frames.
- R4: If no `hsync` rising edge arrives for HS_TIMEOUT reference cycles, the sync check fails and the frame history is cleared. The check can pass again after the strobes resume and three equal frames are seen.
- R5: Once a frame length is known, the sync check fails if no `vsync` rising edge arrives within twice that length (in reference cycles). The frame history is then cleared.
- R6: A low `pll_locked` or a low `clk_present` fails the timing check.
- R7: Each check has its own bypass. `defeat_pll` ignores `pll_locked`, `defeat_sync` ignores the sync checks, and `defeat_clk` ignores `clk_present`. With all three bypasses high, `timing_ok` is 1 regardless of the monitored inputs.
- R8: While `panel_on` is 1, a failing check drives `fault_req` to 1 and `timing_ok` to 0. `fault_req` stays 1 until `panel_on` is 0, then falls within a few cycles.
- R9: While `panel_on` is 0, a failing check only drops `timing_ok`, and `fault_req` stays 0.
- R10: `timing_ok` and `fault_req` are never 1 together, and `timing_ok` cannot rise in the cycle right after `fault_req` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync strobe, asynchronous, rising edge used |
| vsync | input | 1 | Vertical sync strobe, asynchronous, rising edge used |
| clk_present | input | 1 | Level: input pixel clock detected |
| pll_locked | input | 1 | Level: output PLL in lock |
| defeat_pll | input | 1 | Bypass the PLL lock check |
| defeat_sync | input | 1 | Bypass the sync count and timeout checks |
| defeat_clk | input | 1 | Bypass the clock-present check |
| panel_on | input | 1 | Sequencer status: panel currently powered |
| timing_ok | output | 1 | Timing stable, power-up permitted |
| fault_req | output | 1 | Request for power-down sequence |

## Verification
A corrupted run counter or reference count shows up at the ports as `timing_ok` rising one frame early or one frame late after a restart. This is visible within one frame period of the vertical strobe that should have settled the decision. A watchdog counter that is off by a factor of two or never expires shows up as `fault_req` failing to appear, or appearing too early. The bench sees this within a few tens of cycles of the boundary it brackets. A wrong controller transition shows up immediately as a missing or stuck `fault_req`, or as `timing_ok` and `fault_req` out of step with `panel_on`.

// File: rtl/psg_pkg.sv
package psg_pkg;

    typedef enum logic [1:0] {
        MON_WAIT = 2'd0,
        MON_GOOD = 2'd1,
        MON_TRIP = 2'd2
    } mon_state_t;

    typedef enum logic {
        HIST_EMPTY = 1'b0,
        HIST_TRACK = 1'b1
    } hist_state_t;

endpackage

// File: rtl/psg_level_sync.sv
module psg_level_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/psg_edge_sync.sv
module psg_edge_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] rise
);
    logic [W-1:0] cur;
    logic [W-1:0] prev;

    psg_level_sync #(.W(W), .STAGES(STAGES)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (d),
        .q     (cur)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    assign rise = cur & ~prev;
endmodule

// File: rtl/psg_watchdogs.sv
module psg_watchdogs #(
    parameter int HS_TIMEOUT = 458,
    parameter int FRM_W      = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_rise,
    input  logic vs_rise,
    output logic hs_lost,
    output logic vs_lost
);
    localparam int HS_W = $clog2(HS_TIMEOUT + 1);
    localparam logic [HS_W-1:0] HS_LAST = HS_W'(HS_TIMEOUT - 1);

    logic [HS_W-1:0]  hs_cnt;
    logic [FRM_W:0]   frm_cnt;
    logic [FRM_W-1:0] last_len;
    logic             seen_vs;
    logic             len_valid;

    // line watchdog: cycles since the last hsync edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_cnt  <= '0;
            hs_lost <= 1'b0;
        end else if (hs_rise) begin
            hs_cnt  <= '0;
            hs_lost <= 1'b0;
        end else if (!hs_lost) begin
            if (hs_cnt == HS_LAST) hs_lost <= 1'b1;
            else                   hs_cnt  <= hs_cnt + 1'b1;
        end
    end

    // frame length measurement and frame watchdog
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_cnt   <= '0;
            last_len  <= '0;
            seen_vs   <= 1'b0;
            len_valid <= 1'b0;
            vs_lost   <= 1'b0;
        end else if (vs_rise) begin
            frm_cnt <= {{FRM_W{1'b0}}, 1'b1};
            seen_vs <= 1'b1;
            vs_lost <= 1'b0;
            if (seen_vs) begin
                last_len  <= frm_cnt[FRM_W] ? {FRM_W{1'b1}} : frm_cnt[FRM_W-1:0];
                len_valid <= 1'b1;
            end
        end else begin
            if (!(&frm_cnt)) frm_cnt <= frm_cnt + 1'b1;
            if (len_valid && (frm_cnt >= {last_len, 1'b0})) vs_lost <= 1'b1;
        end
    end
endmodule

// File: rtl/psg_frame_hist.sv
module psg_frame_hist
    import psg_pkg::*;
#(
    parameter int LINE_W     = 12,
    parameter int REQ_FRAMES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_rise,
    input  logic vs_rise,
    input  logic clear,
    output logic stable
);
    localparam int RUN_W = $clog2(REQ_FRAMES + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(REQ_FRAMES);

    hist_state_t       hstate;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] ref_cnt;
    logic [RUN_W-1:0]  run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hstate   <= HIST_EMPTY;
            line_cnt <= '0;
            ref_cnt  <= '0;
            run      <= '0;
        end else if (clear) begin
            hstate   <= HIST_EMPTY;
            line_cnt <= '0;
            run      <= '0;
        end else if (vs_rise) begin
            line_cnt <= hs_rise ? {{(LINE_W-1){1'b0}}, 1'b1} : '0;
            ref_cnt  <= line_cnt;
            unique case (hstate)
                HIST_EMPTY: begin
                    hstate <= HIST_TRACK;
                    run    <= '0;
                end
                HIST_TRACK: begin
                    if (run == '0 || line_cnt == ref_cnt) begin
                        if (run != RUN_FULL) run <= run + 1'b1;
                    end else begin
                        run <= {{(RUN_W-1){1'b0}}, 1'b1};
                    end
                end
            endcase
        end else if (hs_rise && !(&line_cnt)) begin
            line_cnt <= line_cnt + 1'b1;
        end
    end

    assign stable = (hstate == HIST_TRACK) && (run == RUN_FULL);
endmodule

// File: rtl/panel_sync_guard.sv
module panel_sync_guard
    import psg_pkg::*;
#(
    parameter int HS_TIMEOUT  = 458,
    parameter int LINE_W      = 12,
    parameter int FRM_W       = 24,
    parameter int REQ_FRAMES  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    input  logic vsync,
    input  logic clk_present,
    input  logic pll_locked,
    input  logic defeat_pll,
    input  logic defeat_sync,
    input  logic defeat_clk,
    input  logic panel_on,
    output logic timing_ok,
    output logic fault_req
);
    logic [1:0] strobe_rise;
    logic [1:0] level_q;
    logic       hs_rise;
    logic       vs_rise;
    logic       hs_lost;
    logic       vs_lost;
    logic       hist_stable;
    logic       sync_ok;
    logic       cond_ok;

    mon_state_t state;
    mon_state_t nxt;

    psg_edge_sync #(.W(2), .STAGES(SYNC_STAGES)) u_strobes (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({vsync, hsync}),
        .rise  (strobe_rise)
    );

    psg_level_sync #(.W(2), .STAGES(SYNC_STAGES)) u_levels (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pll_locked, clk_present}),
        .q     (level_q)
    );

    assign hs_rise = strobe_rise[0];
    assign vs_rise = strobe_rise[1];

    psg_watchdogs #(.HS_TIMEOUT(HS_TIMEOUT), .FRM_W(FRM_W)) u_dogs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_rise (hs_rise),
        .vs_rise (vs_rise),
        .hs_lost (hs_lost),
        .vs_lost (vs_lost)
    );

    psg_frame_hist #(.LINE_W(LINE_W), .REQ_FRAMES(REQ_FRAMES)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_rise (hs_rise),
        .vs_rise (vs_rise),
        .clear   (hs_lost | vs_lost),
        .stable  (hist_stable)
    );

    assign sync_ok = hist_stable & ~hs_lost & ~vs_lost;
    assign cond_ok = (defeat_sync | sync_ok)
                   & (defeat_pll  | level_q[1])
                   & (defeat_clk  | level_q[0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MON_WAIT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            MON_WAIT: begin
                if (cond_ok)       nxt = MON_GOOD;
                else if (panel_on) nxt = MON_TRIP;
            end
            MON_GOOD: begin
                if (!cond_ok) nxt = panel_on ? MON_TRIP : MON_WAIT;
            end
            MON_TRIP: begin
                if (!panel_on) nxt = MON_WAIT;
            end
            default: nxt = MON_WAIT;
        endcase
    end

    always_comb begin
        timing_ok = (state == MON_GOOD);
        fault_req = (state == MON_TRIP);
    end
endmodule

// File: rtl/psg_checker.sv
module psg_checker (
    input logic clk,
    input logic rst_n,
    input logic panel_on,
    input logic timing_ok,
    input logic fault_req,
    input logic hs_rise,
    input logic vs_rise,
    input logic hs_lost,
    input logic vs_lost,
    input logic hist_stable
);
    AST_FAULT_NEEDS_PANEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_req) |-> $past(panel_on)); // R8
    AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req && panel_on |=> fault_req); // R8
    AST_GOOD_DROP_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timing_ok) && $past(panel_on) |-> fault_req); // R8
    AST_QUIET_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timing_ok) && !$past(panel_on) |-> !fault_req); // R9
    AST_NO_GOOD_AFTER_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timing_ok) |-> !$past(fault_req)); // R10
    AST_LINE_DOG_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise |=> !hs_lost); // R4
    AST_FRAME_DOG_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> !vs_lost); // R5
    AST_LOSS_CLEARS_HIST: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_lost || vs_lost) |=> !hist_stable); // R4
endmodule

bind panel_sync_guard psg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .panel_on    (panel_on),
    .timing_ok   (timing_ok),
    .fault_req   (fault_req),
    .hs_rise     (hs_rise),
    .vs_rise     (vs_rise),
    .hs_lost     (hs_lost),
    .vs_lost     (vs_lost),
    .hist_stable (hist_stable)
);

// File: tb/panel_sync_guard_test.sv
`timescale 1ns/1ps
module panel_sync_guard_test;
    localparam int LINE_CYC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync = 1'b0, vsync = 1'b0;
    logic clk_present = 1'b0, pll_locked = 1'b0;
    logic defeat_pll = 1'b0, defeat_sync = 1'b0, defeat_clk = 1'b0;
    logic panel_on = 1'b0;
    logic timing_ok, fault_req;

    int total = 0;
    int bad = 0;
    bit timed_out = 0;

    // stimulus generator state
    bit hs_en = 0, vs_en = 0;
    int lines_cfg = 4;
    int cur_lines = 4;
    int pos = 0;
    int frame_no = 0;

    always #10 clk = ~clk;

    panel_sync_guard #(
        .HS_TIMEOUT (20),
        .LINE_W     (8),
        .FRM_W      (12),
        .REQ_FRAMES (3),
        .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .clk_present(clk_present), .pll_locked(pll_locked),
        .defeat_pll(defeat_pll), .defeat_sync(defeat_sync), .defeat_clk(defeat_clk),
        .panel_on(panel_on), .timing_ok(timing_ok), .fault_req(fault_req)
    );

    // line = 8 cycles, hsync high for 2; vsync high at cycles 4..5 of line 0
    always @(negedge clk) begin
        if (pos == LINE_CYC * cur_lines - 1) begin
            pos = 0;
            cur_lines = lines_cfg;
            frame_no++;
        end else begin
            pos++;
        end
        hsync = hs_en && ((pos % LINE_CYC) < 2);
        vsync = vs_en && (pos >= 4) && (pos < 6);
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic next_frame();
        @(frame_no);
    endtask

    task automatic frame_to(input int n);
        while (frame_no < n) @(frame_no);
    endtask

    task automatic run_all();
        int mark;
        // R1 reset state
        cyc(3);
        chk("R1 timing_ok in reset", timing_ok, 1'b0);
        chk("R1 fault_req in reset", fault_req, 1'b0);
        rst_n = 1'b1;
        pll_locked = 1'b1;
        clk_present = 1'b1;
        cyc(2);
        chk("R1 timing_ok after reset", timing_ok, 1'b0);
        chk("R1 fault_req after reset", fault_req, 1'b0);

        // R2 three equal frames needed
        next_frame();
        mark = frame_no;
        hs_en = 1;
        next_frame();
        vs_en = 1;
        frame_to(mark + 3);
        cyc(12);
        chk("R2 two frames not enough", timing_ok, 1'b0);
        frame_to(mark + 4);
        cyc(12);
        chk("R2 three equal frames", timing_ok, 1'b1);

        // R6 R7 R9 sweep with healthy sync
        for (int i = 0; i < 32; i++) begin
            logic [4:0] v;
            logic e;
            v = 5'(i);
            {defeat_pll, defeat_sync, defeat_clk, pll_locked, clk_present} = v;
            cyc(6);
            e = (v[4] | v[1]) & (v[2] | v[0]);
            chk("R6/R7 sweep, sync good", timing_ok, e);
            chk("R9 no fault with panel off", fault_req, 1'b0);
        end
        // sweep with sync lost (hsync stopped)
        next_frame();
        hs_en = 0;
        cyc(40);
        for (int i = 0; i < 32; i++) begin
            logic [4:0] v;
            logic e;
            v = 5'(i);
            {defeat_pll, defeat_sync, defeat_clk, pll_locked, clk_present} = v;
            cyc(6);
            e = (v[4] | v[1]) & (v[2] | v[0]) & v[3];
            chk("R7 sweep, sync lost", timing_ok, e);
            chk("R9 no fault with panel off", fault_req, 1'b0);
        end
        {defeat_pll, defeat_sync, defeat_clk} = 3'b000;
        pll_locked = 1'b1;
        clk_present = 1'b1;
        next_frame();
        mark = frame_no;
        hs_en = 1;
        frame_to(mark + 5);
        cyc(12);
        chk("R4 recovery after hsync resumes", timing_ok, 1'b1);

        // R3 R8 mismatch with panel on
        panel_on = 1'b1;
        next_frame();
        mark = frame_no;
        lines_cfg = 5;
        next_frame();
        lines_cfg = 4;
        next_frame();
        cyc(12);
        chk("R3/R8 mismatch trips fault", fault_req, 1'b1);
        chk("R10 timing_ok low during fault", timing_ok, 1'b0);
        cyc(10);
        chk("R8 fault held while panel on", fault_req, 1'b1);
        panel_on = 1'b0;
        cyc(3);
        chk("R8 fault released", fault_req, 1'b0);
        frame_to(mark + 4);
        cyc(12);
        chk("R3 two frames after mismatch", timing_ok, 1'b0);
        frame_to(mark + 5);
        cyc(12);
        chk("R3 three frames after mismatch", timing_ok, 1'b1);

        // R4 hsync timeout with panel on
        panel_on = 1'b1;
        next_frame();
        hs_en = 0;
        cyc(12);
        chk("R4 before line timeout", fault_req, 1'b0);
        chk("R4 still good before timeout", timing_ok, 1'b1);
        cyc(28);
        chk("R4 line timeout trips", fault_req, 1'b1);
        chk("R10 exclusive outputs", timing_ok & fault_req, 1'b0);
        panel_on = 1'b0;
        cyc(3);
        chk("R8 release after line loss", fault_req, 1'b0);
        next_frame();
        mark = frame_no;
        hs_en = 1;
        frame_to(mark + 5);
        cyc(12);
        chk("R4 good again", timing_ok, 1'b1);

        // R5 vsync timeout with panel on (frame = 32 cycles, limit 64)
        panel_on = 1'b1;
        next_frame();
        vs_en = 0;
        cyc(24);
        chk("R5 before frame timeout", fault_req, 1'b0);
        cyc(32);
        chk("R5 frame timeout trips", fault_req, 1'b1);
        chk("R10 timing_ok low on frame loss", timing_ok, 1'b0);
        panel_on = 1'b0;
        cyc(3);
        chk("R8 release after frame loss", fault_req, 1'b0);

        // R7 all bypassed with every monitor bad
        pll_locked = 1'b0;
        clk_present = 1'b0;
        {defeat_pll, defeat_sync, defeat_clk} = 3'b111;
        cyc(6);
        chk("R7 all bypassed", timing_ok, 1'b1);
        panel_on = 1'b1;
        cyc(10);
        chk("R7 no fault when bypassed", fault_req, 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule